// File: doc/BRIEF.md
# Low-power SDRAM extended mode register

This block holds the extended configuration register of a low-power SDRAM device. It also holds the logic that decides which parts of the array keep their refresh while the device is in self refresh. A command is a write to this register when it is a mode-register-set command and its bank-address code is 2'b10 (upper bit 1, lower bit 0). The block takes the write only when every bank is idle, no burst is running and the reserved address bits are all zero. Every other attempt at a write is thrown away and raises a one-cycle illegal-operation pulse.

After a write is taken, the block stays busy for a set number of cycles. Any command that arrives while it is busy is flagged as illegal and has no effect. The register contents change only on a taken write or on power-on reset. Deep power-down leaves them as they are. During self refresh the block puts out a refresh enable mask with one bit for each quarter of each bank, chosen by the partial-array field. Regions left out of the mask are marked as having lost their data. A refresh-interval multiplier output follows the temperature field.

Top module: `lpdram_xmr`

## Requirements
- R1: After reset: temperature field 2'b11 (85 °C), partial-array field 3'b000 (all banks), drive field 2'b00 (full strength), busy 0, illegal 0, lost mask all zero.
- R2: A taken write stores cmd_addr[4:3] into the temperature field, cmd_addr[2:0] into the partial-array field and cmd_addr[6:5] into the drive field. The new values appear at the outputs in the cycle after the command.
- R3: A mode-register-set command whose bank code is not 2'b10 leaves the register unchanged and raises no illegal pulse.
- R4: A write that arrives while any bank_idle bit is 0 or burst_active is 1 is discarded, and illegal is 1 in the next cycle.
- R5: A write with any nonzero bit in cmd_addr[ADDR_W-1:7] is discarded, and illegal is 1 in the next cycle.
- R6: A write with partial-array code 3'b011, 3'b100 or 3'b111 (the reserved codes) is discarded, and illegal is 1 in the next cycle.
- R7: After a taken write, busy is 1 for exactly WAIT_CYC cycles. Any command that arrives while busy is 1 is ignored and raises illegal in the next cycle.
- R8: deep_pd has no effect on the register contents.
- R9: ref_mult is 4'b0001 for temperature code 11, 4'b0010 for 00, 4'b0100 for 01 and 4'b1000 for 10.
- R10: While self_refresh is 1, refresh_mask bit b*4+q enables quarter q of bank b. The partial-array code gives the mask: 000→16'hFFFF, 001→16'h00FF, 010→16'h000F, 101→16'h0003, 110→16'h0001. While self_refresh is 0 the mask is zero.
- R11: In each cycle with self_refresh at 1, every region outside the current mask gets its lost bit set at the next edge. Only reset clears a lost bit, and no lost bit changes while self_refresh is 0.
- R12: A command that is not a mode-register-set command (a read or a write to the array) never raises illegal while busy is 0, whatever the partial-array setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_mrs | input | 1 | The command is a mode-register-set |
| cmd_ba | input | 2 | Bank-address code of the command |
| cmd_addr | input | ADDR_W | Address bits that carry the register value |
| bank_idle | input | 4 | Idle status of each bank |
| burst_active | input | 1 | A burst is in progress |
| self_refresh | input | 1 | Device is in self refresh |
| deep_pd | input | 1 | Device is in deep power-down |
| tcsr | output | 2 | Temperature field |
| pasr | output | 3 | Partial-array field |
| drive | output | 2 | Drive-strength field |
| ref_mult | output | 4 | One-hot refresh-interval multiplier |
| busy | output | 1 | Wait time after a write is running |
| illegal | output | 1 | Illegal-operation pulse for the previous cycle's command |
| refresh_mask | output | 16 | Quarter-bank refresh enables during self refresh |
| lost | output | 16 | Sticky flags for regions whose data was lost |

## Verification
Two things can happen in the same cycle. One is a new write that arrives on the last busy cycle, or on the first cycle after it. The bench sends back-to-back writes at random gaps so that both cases occur, and its model expects a rejection in the first case and a taken write in the second. The other is a write that changes the partial-array code while self refresh is on. In that cycle the lost flags must be updated from the old mask, and the new mask must appear only in the next cycle. Random self-refresh levels mixed with writes produce this case, and it is judged each cycle against the bench's mask and lost model.

// File: rtl/lpdram_xmr.sv
module lpdram_xmr #(
  parameter int ADDR_W   = 12,
  parameter int WAIT_CYC = 3,
  localparam int CW      = $clog2(WAIT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_mrs,
  input  logic [1:0]        cmd_ba,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [3:0]        bank_idle,
  input  logic              burst_active,
  input  logic              self_refresh,
  input  logic              deep_pd,
  output logic [1:0]        tcsr,
  output logic [2:0]        pasr,
  output logic [1:0]        drive,
  output logic [3:0]        ref_mult,
  output logic              busy,
  output logic              illegal,
  output logic [15:0]       refresh_mask,
  output logic [15:0]       lost
);

  function automatic logic [15:0] region_sel(input logic [2:0] code);
    case (code)
      3'b000:  return 16'hFFFF;
      3'b001:  return 16'h00FF;
      3'b010:  return 16'h000F;
      3'b101:  return 16'h0003;
      3'b110:  return 16'h0001;
      default: return 16'h0000;
    endcase
  endfunction

  logic [CW-1:0] wait_cnt;
  logic          ext_wr, code_rsvd, bad_wr, take;
  logic [15:0]   sel;

  assign ext_wr    = cmd_valid && cmd_mrs && cmd_ba == 2'b10;
  assign code_rsvd = cmd_addr[2:0] inside {3'b011, 3'b100, 3'b111};
  assign bad_wr    = !(&bank_idle) || burst_active || (|cmd_addr[ADDR_W-1:7]) || code_rsvd;
  assign take      = ext_wr && !busy && !bad_wr;
  assign busy      = wait_cnt != '0;
  assign sel       = region_sel(pasr);
  assign refresh_mask = self_refresh ? sel : 16'h0000;

  always_comb begin
    case (tcsr)
      2'b11:   ref_mult = 4'b0001;
      2'b00:   ref_mult = 4'b0010;
      2'b01:   ref_mult = 4'b0100;
      default: ref_mult = 4'b1000;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcsr     <= 2'b11;
      pasr     <= 3'b000;
      drive    <= 2'b00;
      wait_cnt <= '0;
      illegal  <= 1'b0;
      lost     <= 16'h0000;
    end else begin
      illegal <= cmd_valid && (busy || (ext_wr && bad_wr));
      if (take) begin
        tcsr     <= cmd_addr[4:3];
        pasr     <= cmd_addr[2:0];
        drive    <= cmd_addr[6:5];
        wait_cnt <= CW'(WAIT_CYC);
      end else if (busy) begin
        wait_cnt <= wait_cnt - 1'b1;
      end
      if (self_refresh)
        lost <= lost | ~sel;
    end
  end

  logic unused_ok;
  assign unused_ok = deep_pd;

endmodule

// File: rtl/lpdram_xmr_chk.sv
module lpdram_xmr_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_mrs,
  input logic [1:0]        cmd_ba,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [3:0]        bank_idle,
  input logic              burst_active,
  input logic              self_refresh,
  input logic [1:0]        tcsr,
  input logic [2:0]        pasr,
  input logic [1:0]        drive,
  input logic              busy,
  input logic              illegal,
  input logic [15:0]       refresh_mask,
  input logic [15:0]       lost
);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_mrs && cmd_ba == 2'b10) |=> $stable({tcsr, pasr, drive}));

  p_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mrs && cmd_ba == 2'b10 && (!(&bank_idle) || burst_active))
    |=> (illegal && $stable({tcsr, pasr, drive})));

  p_rsvd_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_mrs && cmd_ba == 2'b10 && (|cmd_addr[ADDR_W-1:7]))
    |=> (illegal && $stable({tcsr, pasr, drive})));

  p_busy_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> (illegal && $stable({tcsr, pasr, drive})));

  p_nomask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !self_refresh |-> refresh_mask == 16'h0000);

  p_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !self_refresh |=> $stable(lost));

  p_array_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_mrs && !busy) |=> !illegal);

endmodule

bind lpdram_xmr lpdram_xmr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_lpdram_xmr.sv
`timescale 1ns/1ps
module sim_lpdram_xmr;
  localparam int AW = 12;
  localparam int WC = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_mrs = 0, burst_active = 0, self_refresh = 0, deep_pd = 0;
  logic [1:0] cmd_ba = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic [3:0] bank_idle = 4'hF;
  logic [1:0] tcsr, drive;
  logic [2:0] pasr;
  logic [3:0] ref_mult;
  logic busy, illegal;
  logic [15:0] refresh_mask, lost;

  lpdram_xmr #(.ADDR_W(AW), .WAIT_CYC(WC)) u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [1:0] m_t, m_d;
  logic [2:0] m_p;
  int m_cnt;
  logic m_ill;
  logic [15:0] m_lost;

  function automatic logic [15:0] fmask(input logic [2:0] p);
    case (p)
      3'b000: return 16'hFFFF; 3'b001: return 16'h00FF; 3'b010: return 16'h000F;
      3'b101: return 16'h0003; 3'b110: return 16'h0001; default: return 16'h0000;
    endcase
  endfunction
  function automatic logic [3:0] fmult(input logic [1:0] t);
    case (t)
      2'b11: return 4'b0001; 2'b00: return 4'b0010; 2'b01: return 4'b0100; default: return 4'b1000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic mreset();
    m_t = 2'b11; m_p = 0; m_d = 0; m_cnt = 0; m_ill = 0; m_lost = 0;
  endtask

  task automatic step(input logic v, input logic mrs, input logic [1:0] ba, input logic [AW-1:0] a,
                      input logic [3:0] idle, input logic bu, input logic sr, input logic dp);
    logic ew, bad, tk;
    @(negedge clk);
    cmd_valid = v; cmd_mrs = mrs; cmd_ba = ba; cmd_addr = a;
    bank_idle = idle; burst_active = bu; self_refresh = sr; deep_pd = dp;
    ew  = v && mrs && ba == 2'b10;
    bad = !(&idle) || bu || (|a[AW-1:7]) || (a[2:0] inside {3'b011, 3'b100, 3'b111});
    tk  = ew && m_cnt == 0 && !bad;
    m_ill = v && (m_cnt != 0 || (ew && bad));
    if (sr) m_lost = m_lost | ~fmask(m_p);
    if (tk) begin m_t = a[4:3]; m_p = a[2:0]; m_d = a[6:5]; m_cnt = WC; end
    else if (m_cnt != 0) m_cnt--;
    @(posedge clk); #1;
    chk("R2 fields", {tcsr, pasr, drive}, {m_t, m_p, m_d});
    chk("R7 busy", busy, m_cnt != 0);
    chk("R4 illegal", illegal, m_ill);
    chk("R9 ref_mult", ref_mult, fmult(m_t));
    chk("R10 mask", refresh_mask, sr ? fmask(m_p) : 16'h0);
    chk("R11 lost", lost, m_lost);
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 4'hF, 0, 0, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    mreset();
    #12 rst_n = 1;
    #1;
    chk("R1 reset fields", {tcsr, pasr, drive}, {2'b11, 3'b000, 2'b00});
    chk("R1 reset busy/illegal/lost", {busy, illegal, lost}, 18'h0);

    step(1, 1, 2'b10, 12'h05A, 4'hF, 0, 0, 0);
    chk("R2 write tcsr=11 pasr=010 drive=10", {tcsr, pasr, drive}, {2'b11, 3'b010, 2'b10});
    step(1, 1, 2'b10, 12'h000, 4'hF, 0, 0, 0);
    chk("R7 cmd while busy flagged", illegal, 1'b1);
    idle_n(WC);
    chk("R7 busy ends after WAIT_CYC", busy, 1'b0);

    step(1, 1, 2'b00, 12'h000, 4'hF, 0, 0, 0);
    chk("R3 other bank code ignored", {illegal, pasr}, {1'b0, 3'b010});
    step(1, 1, 2'b10, 12'h000, 4'hB, 0, 0, 0);
    chk("R4 bank busy discarded", {illegal, pasr}, {1'b1, 3'b010});
    step(1, 1, 2'b10, 12'h080, 4'hF, 0, 0, 0);
    chk("R5 reserved bit discarded", {illegal, pasr}, {1'b1, 3'b010});
    step(1, 1, 2'b10, 12'h003, 4'hF, 0, 0, 0);
    chk("R6 reserved code discarded", {illegal, pasr}, {1'b1, 3'b010});
    step(1, 1, 2'b10, 12'h006, 4'hF, 0, 0, 0);
    idle_n(WC);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 4'hF, 0, 0, 1);
    chk("R8 deep power-down keeps contents", {tcsr, pasr, drive}, {2'b00, 3'b110, 2'b00});
    step(1, 0, 2'b11, 12'h000, 4'h0, 1, 0, 0);
    chk("R12 array command legal", illegal, 1'b0);
    step(0, 0, 0, 0, 4'hF, 0, 1, 0);
    chk("R10 quarter bank mask", refresh_mask, 16'h0001);
    step(0, 0, 0, 0, 4'hF, 0, 0, 0);
    chk("R11 lost after quarter self refresh", lost, 16'hFFFE);

    rst_n = 0; #1; mreset(); #10 rst_n = 1;
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom);
      if ($urandom_range(0, 9) != 0) a[AW-1:7] = '0;
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0,
           ($urandom_range(0, 3) != 0) ? 2'b10 : 2'($urandom),
           a, ($urandom_range(0, 4) != 0) ? 4'hF : 4'($urandom),
           $urandom_range(0, 9) == 0, $urandom_range(0, 7) == 0, 1'($urandom));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule